// File: doc/BRIEF.md
# Register Cache Stage for a Counterflow Pipeline

This block is a small register cache that behaves as one ordinary stage of a counterflow pipeline, placed close to the decode end. Instructions travel through it in one direction and results travel past it in the other. When an instruction passes, each of its source registers is looked up. If the cache holds a valid copy, the stage fills the operand value into the instruction. If it does not, the stage raises an operand request toward the register file that carries the register name.

Results that pass the stage are written into the cache and marked valid. An instruction that will write a register invalidates that register's entry, because any later value would otherwise be stale. A trap or a wrong-branch result does not try to track which entries are affected. Instead it sweeps every valid bit clear at once.

The stage registers its outputs. An instruction presented in one cycle appears at the outputs one clock later, together with its fill flags, its operand values and its operand requests. Lookups use the cache contents as they stood before that clock edge.

Top module: `regCacheStage`

## Requirements
- R1: An instruction presented with `instValidIn` high appears one clock later with `instValidOut` high, and its register names, use flags and destination fields are copied unchanged. A cycle without an instruction gives `instValidOut` low and `srcAFullOut`, `srcBFullOut`, `reqAValidOut` and `reqBValidOut` low.
- R2: A used source whose register holds a valid entry before the edge produces a fill flag of 1 and the stored value on its value output. A source that is unused or misses produces a fill flag of 0 and a value of 0.
- R3: A result presented with `resValidIn` high and no flush writes its value into the entry it names and marks that entry valid. Instructions presented in any later cycle see the write.
- R4: An instruction with `instDestEnIn` high marks the entry of its destination register invalid at that edge. Later readers of that register miss until a new result arrives.
- R5: A flush clears every valid bit in one cycle. No source is filled for an instruction presented in the flush cycle.
- R6: When a result write and an invalidating destination name the same entry in the same cycle, the entry ends invalid.
- R7: A result presented in a flush cycle is discarded, and its register stays invalid afterwards.
- R8: For each used source that is not filled, the stage raises the matching request flag for exactly the one output cycle of that instruction, with the register name on the request register-name output. An unused source or a filled source never raises a request.
- R9: After reset every entry is invalid and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instValidIn | input | 1 | An instruction is present this cycle |
| instSrcAIn | input | 5 | First source register name |
| instSrcAUseIn | input | 1 | First source is used |
| instSrcBIn | input | 5 | Second source register name |
| instSrcBUseIn | input | 1 | Second source is used |
| instDestIn | input | 5 | Destination register name |
| instDestEnIn | input | 1 | Instruction may write its destination |
| resValidIn | input | 1 | A result passes this cycle |
| resRegIn | input | 5 | Register named by the result |
| resDataIn | input | 32 | Result value |
| flushIn | input | 1 | Trap or wrong-branch result reaches the stage |
| instValidOut | output | 1 | Instruction present at output |
| instSrcAOut | output | 5 | First source name |
| instSrcAUseOut | output | 1 | First source use flag |
| instSrcBOut | output | 5 | Second source name |
| instSrcBUseOut | output | 1 | Second source use flag |
| instDestOut | output | 5 | Destination name |
| instDestEnOut | output | 1 | Destination write flag |
| srcAFullOut | output | 1 | First operand was filled from the cache |
| srcAValOut | output | 32 | First operand value, 0 if not filled |
| srcBFullOut | output | 1 | Second operand was filled from the cache |
| srcBValOut | output | 32 | Second operand value, 0 if not filled |
| reqAValidOut | output | 1 | Request for the first source |
| reqARegOut | output | 5 | Register named by the first request |
| reqBValidOut | output | 1 | Request for the second source |
| reqBRegOut | output | 5 | Register named by the second request |

## Verification
The hardest situations to reach are those where several updates meet on one entry within a single edge. One case is a result write and an invalidating destination naming the same register. Another is a flush arriving together with a write, and a third is a lookup taken in the cycle right after either of these. Directed sequences build each collision and then read the entry back through a following instruction. The random phase draws register names from a small pool, so hits, misses, overlaps between write and invalidate, and flushes occur often and in every order.

// File: rtl/regCachePkg.sv
package regCachePkg;
  typedef struct packed {
    logic flushAll;
    logic wrEn;
    logic invEn;
    logic fillA;
    logic fillB;
    logic capture;
  } cacheCtl_t;
endpackage

// File: rtl/regCacheCtrl.sv
module regCacheCtrl
  import regCachePkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValidIn,
  input  logic             instSrcAUseIn,
  input  logic             instSrcBUseIn,
  input  logic [IDX_W-1:0] instSrcAIn,
  input  logic [IDX_W-1:0] instSrcBIn,
  input  logic             instDestEnIn,
  input  logic             resValidIn,
  input  logic             flushIn,
  input  logic             hitA,
  input  logic             hitB,
  output cacheCtl_t        ctl,
  output logic             reqAValidOut,
  output logic [IDX_W-1:0] reqARegOut,
  output logic             reqBValidOut,
  output logic [IDX_W-1:0] reqBRegOut
);
  logic needA, needB;

  always_comb begin
    ctl          = '0;
    ctl.flushAll = flushIn;
    ctl.wrEn     = resValidIn && !flushIn;
    ctl.invEn    = instValidIn && instDestEnIn;
    ctl.capture  = instValidIn;
    ctl.fillA    = instValidIn && instSrcAUseIn && hitA && !flushIn;
    ctl.fillB    = instValidIn && instSrcBUseIn && hitB && !flushIn;
    needA        = instValidIn && instSrcAUseIn && !ctl.fillA;
    needB        = instValidIn && instSrcBUseIn && !ctl.fillB;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAValidOut <= 1'b0;
      reqBValidOut <= 1'b0;
      reqARegOut   <= '0;
      reqBRegOut   <= '0;
    end else begin
      reqAValidOut <= needA;
      reqBValidOut <= needB;
      reqARegOut   <= needA ? instSrcAIn : '0;
      reqBRegOut   <= needB ? instSrcBIn : '0;
    end
  end
endmodule

// File: rtl/regCacheData.sv
module regCacheData
  import regCachePkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  cacheCtl_t         ctl,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  instSrcAIn,
  input  logic              instSrcAUseIn,
  input  logic [IDX_W-1:0]  instSrcBIn,
  input  logic              instSrcBUseIn,
  input  logic [IDX_W-1:0]  instDestIn,
  input  logic              instDestEnIn,
  output logic              hitA,
  output logic              hitB,
  output logic              instValidOut,
  output logic [IDX_W-1:0]  instSrcAOut,
  output logic              instSrcAUseOut,
  output logic [IDX_W-1:0]  instSrcBOut,
  output logic              instSrcBUseOut,
  output logic [IDX_W-1:0]  instDestOut,
  output logic              instDestEnOut,
  output logic              srcAFullOut,
  output logic [DATA_W-1:0] srcAValOut,
  output logic              srcBFullOut,
  output logic [DATA_W-1:0] srcBValOut
);
  logic [NUM_REGS-1:0] validQ;
  logic [DATA_W-1:0]   store [NUM_REGS];

  for (genvar e = 0; e < NUM_REGS; e++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                        validQ[e] <= 1'b0;
      else if (ctl.flushAll)                            validQ[e] <= 1'b0;
      else if (ctl.invEn && instDestIn == IDX_W'(e))    validQ[e] <= 1'b0;
      else if (ctl.wrEn && wrIdx == IDX_W'(e))          validQ[e] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.wrEn) store[wrIdx] <= wrData;
  end

  assign hitA = validQ[instSrcAIn];
  assign hitB = validQ[instSrcBIn];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      instValidOut   <= 1'b0;
      instSrcAOut    <= '0;
      instSrcAUseOut <= 1'b0;
      instSrcBOut    <= '0;
      instSrcBUseOut <= 1'b0;
      instDestOut    <= '0;
      instDestEnOut  <= 1'b0;
      srcAFullOut    <= 1'b0;
      srcAValOut     <= '0;
      srcBFullOut    <= 1'b0;
      srcBValOut     <= '0;
    end else if (ctl.capture) begin
      instValidOut   <= 1'b1;
      instSrcAOut    <= instSrcAIn;
      instSrcAUseOut <= instSrcAUseIn;
      instSrcBOut    <= instSrcBIn;
      instSrcBUseOut <= instSrcBUseIn;
      instDestOut    <= instDestIn;
      instDestEnOut  <= instDestEnIn;
      srcAFullOut    <= ctl.fillA;
      srcAValOut     <= ctl.fillA ? store[instSrcAIn] : '0;
      srcBFullOut    <= ctl.fillB;
      srcBValOut     <= ctl.fillB ? store[instSrcBIn] : '0;
    end else begin
      instValidOut   <= 1'b0;
      instSrcAOut    <= '0;
      instSrcAUseOut <= 1'b0;
      instSrcBOut    <= '0;
      instSrcBUseOut <= 1'b0;
      instDestOut    <= '0;
      instDestEnOut  <= 1'b0;
      srcAFullOut    <= 1'b0;
      srcAValOut     <= '0;
      srcBFullOut    <= 1'b0;
      srcBValOut     <= '0;
    end
  end
endmodule

// File: rtl/regCacheStage.sv
module regCacheStage
  import regCachePkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValidIn,
  input  logic [IDX_W-1:0]  instSrcAIn,
  input  logic              instSrcAUseIn,
  input  logic [IDX_W-1:0]  instSrcBIn,
  input  logic              instSrcBUseIn,
  input  logic [IDX_W-1:0]  instDestIn,
  input  logic              instDestEnIn,
  input  logic              resValidIn,
  input  logic [IDX_W-1:0]  resRegIn,
  input  logic [DATA_W-1:0] resDataIn,
  input  logic              flushIn,
  output logic              instValidOut,
  output logic [IDX_W-1:0]  instSrcAOut,
  output logic              instSrcAUseOut,
  output logic [IDX_W-1:0]  instSrcBOut,
  output logic              instSrcBUseOut,
  output logic [IDX_W-1:0]  instDestOut,
  output logic              instDestEnOut,
  output logic              srcAFullOut,
  output logic [DATA_W-1:0] srcAValOut,
  output logic              srcBFullOut,
  output logic [DATA_W-1:0] srcBValOut,
  output logic              reqAValidOut,
  output logic [IDX_W-1:0]  reqARegOut,
  output logic              reqBValidOut,
  output logic [IDX_W-1:0]  reqBRegOut
);
  cacheCtl_t ctl;
  logic      hitA, hitB;

  regCacheCtrl #(.IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .instValidIn(instValidIn), .instSrcAUseIn(instSrcAUseIn), .instSrcBUseIn(instSrcBUseIn),
    .instSrcAIn(instSrcAIn), .instSrcBIn(instSrcBIn), .instDestEnIn(instDestEnIn),
    .resValidIn(resValidIn), .flushIn(flushIn), .hitA(hitA), .hitB(hitB), .ctl(ctl),
    .reqAValidOut(reqAValidOut), .reqARegOut(reqARegOut),
    .reqBValidOut(reqBValidOut), .reqBRegOut(reqBRegOut)
  );

  regCacheData #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrIdx(resRegIn), .wrData(resDataIn),
    .instSrcAIn(instSrcAIn), .instSrcAUseIn(instSrcAUseIn),
    .instSrcBIn(instSrcBIn), .instSrcBUseIn(instSrcBUseIn),
    .instDestIn(instDestIn), .instDestEnIn(instDestEnIn),
    .hitA(hitA), .hitB(hitB),
    .instValidOut(instValidOut), .instSrcAOut(instSrcAOut), .instSrcAUseOut(instSrcAUseOut),
    .instSrcBOut(instSrcBOut), .instSrcBUseOut(instSrcBUseOut),
    .instDestOut(instDestOut), .instDestEnOut(instDestEnOut),
    .srcAFullOut(srcAFullOut), .srcAValOut(srcAValOut),
    .srcBFullOut(srcBFullOut), .srcBValOut(srcBValOut)
  );
endmodule

// File: rtl/regCacheChecker.sv
module regCacheChecker #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              instValidIn,
  input logic [IDX_W-1:0]  instSrcAIn,
  input logic              instSrcAUseIn,
  input logic [IDX_W-1:0]  instSrcBIn,
  input logic              instSrcBUseIn,
  input logic [IDX_W-1:0]  instDestIn,
  input logic              instDestEnIn,
  input logic              resValidIn,
  input logic [IDX_W-1:0]  resRegIn,
  input logic [DATA_W-1:0] resDataIn,
  input logic              flushIn,
  input logic              instValidOut,
  input logic [IDX_W-1:0]  instSrcAOut,
  input logic              instSrcAUseOut,
  input logic [IDX_W-1:0]  instSrcBOut,
  input logic              instSrcBUseOut,
  input logic [IDX_W-1:0]  instDestOut,
  input logic              instDestEnOut,
  input logic              srcAFullOut,
  input logic [DATA_W-1:0] srcAValOut,
  input logic              srcBFullOut,
  input logic [DATA_W-1:0] srcBValOut,
  input logic              reqAValidOut,
  input logic [IDX_W-1:0]  reqARegOut,
  input logic              reqBValidOut,
  input logic [IDX_W-1:0]  reqBRegOut
);
  AST_PASS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    instValidIn |=> instValidOut);  // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !instValidIn |=> !instValidOut && !reqAValidOut && !reqBValidOut);  // R1
  AST_FLUSH_NO_FILL: assert property (@(posedge clk) disable iff (!rstN)
    flushIn |=> !srcAFullOut && !srcBFullOut);  // R5
  AST_REQ_OR_FILL: assert property (@(posedge clk) disable iff (!rstN)
    reqAValidOut |-> instValidOut && instSrcAUseOut && !srcAFullOut && reqARegOut == instSrcAOut);  // R8
  AST_REQ_B_OR_FILL: assert property (@(posedge clk) disable iff (!rstN)
    reqBValidOut |-> instValidOut && instSrcBUseOut && !srcBFullOut && reqBRegOut == instSrcBOut);  // R8
  AST_WRITE_HIT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN && resValidIn && !flushIn && !(instValidIn && instDestEnIn && instDestIn == resRegIn))
     && instValidIn && instSrcAUseIn && !flushIn && instSrcAIn == $past(resRegIn))
    |=> srcAFullOut && srcAValOut == $past(resDataIn, 2));  // R3
  AST_INVAL_MISS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN && instValidIn && instDestEnIn) && instValidIn && instSrcAUseIn
     && instSrcAIn == $past(instDestIn))
    |=> !srcAFullOut);  // R4
endmodule

bind regCacheStage regCacheChecker #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_regCacheChecker (.*);

// File: tb/test_regCacheStage.sv
module test_regCacheStage;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_REGS   = 32;
  localparam int DATA_W     = 32;
  localparam int IDX_W      = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValidIn = 0, instSrcAUseIn = 0, instSrcBUseIn = 0, instDestEnIn = 0;
  logic [IDX_W-1:0] instSrcAIn = '0, instSrcBIn = '0, instDestIn = '0, resRegIn = '0;
  logic resValidIn = 0, flushIn = 0;
  logic [DATA_W-1:0] resDataIn = '0;
  logic instValidOut, instSrcAUseOut, instSrcBUseOut, instDestEnOut;
  logic [IDX_W-1:0] instSrcAOut, instSrcBOut, instDestOut, reqARegOut, reqBRegOut;
  logic srcAFullOut, srcBFullOut, reqAValidOut, reqBValidOut;
  logic [DATA_W-1:0] srcAValOut, srcBValOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic              refValid [NUM_REGS];
  logic [DATA_W-1:0] refData  [NUM_REGS];

  always #(CLK_PERIOD/2) clk = ~clk;

  regCacheStage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_regCacheStage (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic expFill(input logic use_, input logic [IDX_W-1:0] r, input logic fl);
    return use_ && refValid[r] && !fl;
  endfunction

  // one cycle: drive at negedge, sample at next negedge, then advance the model
  task automatic step(input logic iv, input logic [IDX_W-1:0] sa, input logic ua,
                      input logic [IDX_W-1:0] sb, input logic ub,
                      input logic [IDX_W-1:0] d, input logic de,
                      input logic rv, input logic [IDX_W-1:0] rr, input logic [DATA_W-1:0] rd,
                      input logic fl, input string tag);
    logic fa, fb, ra, rb;
    logic [DATA_W-1:0] va, vb;
    instValidIn = iv; instSrcAIn = sa; instSrcAUseIn = ua; instSrcBIn = sb; instSrcBUseIn = ub;
    instDestIn = d; instDestEnIn = de; resValidIn = rv; resRegIn = rr; resDataIn = rd; flushIn = fl;
    fa = iv && expFill(ua, sa, fl);
    fb = iv && expFill(ub, sb, fl);
    va = fa ? refData[sa] : '0;
    vb = fb ? refData[sb] : '0;
    ra = iv && ua && !fa;
    rb = iv && ub && !fb;
    @(negedge clk);
    chk(instValidOut == iv, {tag, " R1 valid"}, instValidOut, iv);
    if (iv) chk(instSrcAOut == sa && instSrcBOut == sb && instDestOut == d && instDestEnOut == de
                && instSrcAUseOut == ua && instSrcBUseOut == ub, {tag, " R1 fields"},
                {instSrcAOut, instSrcBOut, instDestOut}, {sa, sb, d});
    chk(srcAFullOut == fa && srcAValOut == va, {tag, " R2 srcA"}, {srcAFullOut, srcAValOut}, {fa, va});
    chk(srcBFullOut == fb && srcBValOut == vb, {tag, " R2 srcB"}, {srcBFullOut, srcBValOut}, {fb, vb});
    chk(reqAValidOut == ra && (!ra || reqARegOut == sa), {tag, " R8 reqA"},
        {reqAValidOut, reqARegOut}, {ra, sa});
    chk(reqBValidOut == rb && (!rb || reqBRegOut == sb), {tag, " R8 reqB"},
        {reqBValidOut, reqBRegOut}, {rb, sb});
    if (fl) begin
      for (int i = 0; i < NUM_REGS; i++) refValid[i] = 1'b0;
    end else begin
      if (rv) begin refData[rr] = rd; refValid[rr] = 1'b1; end
      if (iv && de) refValid[d] = 1'b0;
    end
  endtask

  task automatic readReg(input logic [IDX_W-1:0] r, input string tag);
    step(1, r, 1, r, 1, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NUM_REGS; i++) begin refValid[i] = 0; refData[i] = '0; end
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(instValidOut == 0 && srcAFullOut == 0 && reqAValidOut == 0 && reqBValidOut == 0 && srcAValOut == 0,
        "R9 outputs at reset", {instValidOut, srcAFullOut, reqAValidOut}, 0);
    rstN = 1;
    @(negedge clk);
    for (int i = 0; i < NUM_REGS; i++) readReg(IDX_W'(i), "R9 empty after reset");
    // R3 then R2: write r5, read it
    step(0, 0, 0, 0, 0, 0, 0, 1, 5, 32'hCAFE0005, 0, "R3 write");
    readReg(5, "R2 hit r5");
    // R4 invalidate r5
    step(1, 1, 0, 2, 0, 5, 1, 0, 0, 0, 0, "R4 inval");
    readReg(5, "R4 miss r5");
    // R6 same-cycle write and invalidate on r7
    step(1, 0, 0, 0, 0, 7, 1, 1, 7, 32'h77, 0, "R6 collide");
    readReg(7, "R6 miss r7");
    // R5 flush clears, R7 write discarded
    step(0, 0, 0, 0, 0, 0, 0, 1, 3, 32'h33, 0, "R5 setup");
    step(1, 3, 1, 3, 1, 0, 0, 1, 9, 32'h99, 1, "R5 flush no fill");
    readReg(3, "R5 cleared r3");
    readReg(9, "R7 write dropped r9");
    // R8 unused source never requests
    step(1, 12, 0, 13, 1, 0, 0, 0, 0, 0, 0, "R8 unused A");
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [IDX_W-1:0] pool;
      pool = ($urandom % 4 == 0) ? IDX_W'($urandom) : IDX_W'($urandom % 6);
      step($urandom % 4 != 0, IDX_W'($urandom % 6), $urandom % 2, pool, $urandom % 2,
           IDX_W'($urandom % 6), $urandom % 3 == 0, $urandom % 2, IDX_W'($urandom % 6),
           $urandom, $urandom % 40 == 0, "random R2 R3 R4 R5 R6 R7");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule